// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block lets a host reach a small bank of byte-wide registers over a two-wire serial bus (clock and data, both open-drain). A fast system clock samples both lines. The block finds bus START and STOP conditions and matches a fixed 7-bit device address. It shifts data bytes in and out MSB first, and it acknowledges by asserting an open-drain output enable for SDA. The registers themselves live outside the block. They are reached through a plain port: a combinational read, where the data follows the address in the same cycle, and a one-cycle write strobe.

A write transaction names a register with its first data byte. Each later byte is stored at that location and moves the location forward. The location pointer is kept between transactions. A read can therefore follow a pointer write, joined by a repeated START. A read can also begin cold and continue from wherever the last access stopped. The pointer moves on during a read only when the host acknowledges a byte. While timekeeping registers (locations 0 to 6) are being read, a freeze flag holds off the clock update logic next door. The flag drops on STOP, or when the pointer moves to location 7.

Top module: `tw_reg_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception from any state and abandons a byte in progress. A STOP (SDA rising while SCL is high) returns the block to idle. In idle, clocked bits get no ACK and cause no write.
- R2: The address byte arrives MSB first: 7 address bits, then the direction bit in bit 0 (0 = write, 1 = read). When the address equals 7'h68 (bytes D0h and D1h), sda_oe_o is high during the ninth SCL pulse.
- R3: On an address mismatch, the block gives no ACK, never drives SDA and writes no register until the next START.
- R4: In a write transaction, the first byte after the address is acknowledged and loads the pointer from its low 3 bits. It writes no register.
- R5: Each later write byte is acknowledged and gives a one-cycle reg_wr_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte. The pointer then steps by one.
- R6: In a read, the block sends the byte at the pointer MSB first, one bit per SCL pulse. The pointer steps only when the host drives ACK (SDA low) in the ninth pulse. On NACK the block releases SDA and goes idle, leaving the pointer unchanged.
- R7: The pointer steps from 7 back to 0, on writes and on reads.
- R8: The pointer survives STOP. A read with no pointer write before it starts at the location left by the previous access.
- R9: freeze_o rises when a read begins, or a read step lands, on a location from 0 to 6. It falls when a read step lands on 7, and it clears on STOP.
- R10: A repeated START keeps the pointer. A pointer write followed by a repeated START and a read returns the byte at the loaded location.
- R11: sda_oe_o changes only while SCL is low, a few system clocks after SCL falls.
- R12: In reset and just after it, sda_oe_o, freeze_o and reg_wr_o are 0 and reg_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| freeze_o | output | 1 | Holds the timekeeping update while clock locations are read |
| reg_addr_o | output | 3 | Register location (the pointer) |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, valid in the same cycle |

## Verification
The bench goes after the pointer: at the step from 7 back to 0, after a host NACK, across a STOP, and across a repeated START. A design that steps the pointer on NACK, or clears it on STOP, would return the wrong byte on the next current-location read. It also checks that the freeze flag drops at location 7 and comes back at 0. A design that holds or drops the flag for the whole read would fail those checks. A START or STOP in mid-byte and a foreign address are also sent. A design that finished the partial byte, or answered after a mismatch, would show a stray ACK or a corrupted register.

// File: rtl/tw_pkg.sv
package tw_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned TW_BYTE_W = 8;
  localparam int unsigned TW_CNT_W  = $clog2(TW_BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } tw_state_e;
endpackage

// File: rtl/tw_bus_cond.sv
module tw_bus_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  timeunit 1ns; timeprecision 100ps;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_s, sda_s, scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync[0] <= scl_i;
      sda_sync[0] <= sda_i;
      for (int i = 1; i < int'(SYNC_STAGES); i++) begin
        scl_sync[i] <= scl_sync[i-1];
        sda_sync[i] <= sda_sync[i-1];
      end
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges while clock stays high are bus conditions
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_ptr.sv
module tw_ptr #(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned FREEZE_LAST = 6,
  parameter int unsigned AW          = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          wr_inc_i,
  input  logic          rd_inc_i,
  input  logic          rd_entry_i,
  input  logic          stop_i,
  output logic [AW-1:0] ptr_o,
  output logic          freeze_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [AW-1:0] PTR_TOP = AW'(NUM_REGS - 1);

  logic [AW-1:0] ptr_q, ptr_nxt;
  logic          freeze_q;

  assign ptr_nxt = (ptr_q == PTR_TOP) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_val_i;
    end else if (wr_inc_i || rd_inc_i) begin
      ptr_q <= ptr_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freeze_q <= 1'b0;
    end else if (stop_i) begin
      freeze_q <= 1'b0;
    end else if (rd_entry_i) begin
      freeze_q <= (32'(ptr_q) <= FREEZE_LAST);
    end else if (rd_inc_i) begin
      freeze_q <= (32'(ptr_nxt) <= FREEZE_LAST);
    end
  end

  assign ptr_o    = ptr_q;
  assign freeze_o = freeze_q;
endmodule

// File: rtl/tw_xfer_fsm.sv
module tw_xfer_fsm
  import tw_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h68,
  parameter int unsigned AW       = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sda_i,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [TW_BYTE_W-1:0] rdata_i,
  output logic                 sda_oe_o,
  output logic                 wr_o,
  output logic [TW_BYTE_W-1:0] wdata_o,
  output logic                 ptr_load_o,
  output logic [AW-1:0]        ptr_load_val_o,
  output logic                 rd_inc_o,
  output logic                 rd_entry_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [TW_CNT_W-1:0] LAST_BIT = TW_CNT_W'(TW_BYTE_W);

  tw_state_e            state_q;
  logic [TW_CNT_W-1:0]  cnt_q;
  logic [TW_BYTE_W-1:0] rx_q, tx_q;
  logic                 oe_q, first_q, rw_q;
  logic                 byte_done, addr_hit, quiet, wr_fall;

  assign byte_done = (cnt_q == LAST_BIT);
  assign addr_hit  = (rx_q[TW_BYTE_W-1:1] == DEV_ADDR);
  assign quiet     = ~start_i & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise_i) begin
            rx_q  <= {rx_q[TW_BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall_i && byte_done) begin
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                state_q <= ST_ADDR_ACK;
                oe_q    <= 1'b1;
                rw_q    <= rx_q[0];
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              state_q <= ST_WR_ACK;
              oe_q    <= 1'b1;
              first_q <= 1'b0;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_RD_BYTE;
              tx_q    <= rdata_i;
              oe_q    <= ~rdata_i[TW_BYTE_W-1];
            end else begin
              state_q <= ST_WR_BYTE;
              first_q <= 1'b1;
              oe_q    <= 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            state_q <= ST_WR_BYTE;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
          end
        end
        ST_RD_BYTE: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (byte_done) begin
              state_q <= ST_RD_ACK;
              oe_q    <= 1'b0;
            end else begin
              tx_q <= {tx_q[TW_BYTE_W-2:0], 1'b0};
              oe_q <= ~tx_q[TW_BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              state_q <= ST_RD_BYTE;
              cnt_q   <= '0;
              tx_q    <= rdata_i;
              oe_q    <= ~rdata_i[TW_BYTE_W-1];
            end else begin
              state_q <= ST_IDLE;
              oe_q    <= 1'b0;
            end
          end else if (scl_rise_i) begin
            // rw_q reused as "host acknowledged" for the byte just sent
            rw_q <= ~sda_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_fall        = (state_q == ST_WR_BYTE) && scl_fall_i && byte_done && quiet;
  assign ptr_load_o     = wr_fall & first_q;
  assign wr_o           = wr_fall & ~first_q;
  assign wdata_o        = rx_q;
  assign ptr_load_val_o = rx_q[AW-1:0];
  assign rd_inc_o       = (state_q == ST_RD_ACK) && scl_rise_i && !sda_i && quiet;
  assign rd_entry_o     = (state_q == ST_ADDR_ACK) && scl_fall_i && rw_q && quiet;
  assign sda_oe_o       = oe_q;
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h68,
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned FREEZE_LAST = 6,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  output logic                 freeze_o,
  output logic [AW-1:0]        reg_addr_o,
  output logic                 reg_wr_o,
  output logic [TW_BYTE_W-1:0] reg_wdata_o,
  input  logic [TW_BYTE_W-1:0] reg_rdata_i
);
  timeunit 1ns; timeprecision 100ps;

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          ptr_load, rd_inc, rd_entry;
  logic [AW-1:0] ptr_load_val, ptr_q;

  tw_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tw_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sda_i          (sda_s),
    .scl_rise_i     (scl_rise),
    .scl_fall_i     (scl_fall),
    .start_i        (start_det),
    .stop_i         (stop_det),
    .rdata_i        (reg_rdata_i),
    .sda_oe_o       (sda_oe_o),
    .wr_o           (reg_wr_o),
    .wdata_o        (reg_wdata_o),
    .ptr_load_o     (ptr_load),
    .ptr_load_val_o (ptr_load_val),
    .rd_inc_o       (rd_inc),
    .rd_entry_o     (rd_entry)
  );

  tw_ptr #(.NUM_REGS(NUM_REGS), .FREEZE_LAST(FREEZE_LAST), .AW(AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_load_val),
    .wr_inc_i   (reg_wr_o),
    .rd_inc_i   (rd_inc),
    .rd_entry_i (rd_entry),
    .stop_i     (stop_det),
    .ptr_o      (ptr_q),
    .freeze_o   (freeze_o)
  );

  assign reg_addr_o = ptr_q;
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned FREEZE_LAST = 6,
  parameter int unsigned AW          = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_i,
  input logic          freeze_i,
  input logic          reg_wr_i,
  input logic          stop_i,
  input logic [AW-1:0] ptr_i
);
  timeunit 1ns; timeprecision 100ps;

  logic [AW-1:0] ptr_inc;
  assign ptr_inc = (ptr_i == AW'(NUM_REGS - 1)) ? '0 : ptr_i + 1'b1;

  // R11
  a_r11_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_i);

  // R5
  a_r5_wr_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> !reg_wr_i);

  // R5, R7
  a_r7_wr_steps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> ptr_i == $past(ptr_inc));

  // R9
  a_r9_freeze_rise_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(freeze_i) |-> (32'(ptr_i) <= FREEZE_LAST));

  // R9
  a_r9_freeze_clear_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !freeze_i);
endmodule

bind tw_reg_slave tw_reg_slave_chk #(
  .NUM_REGS(NUM_REGS), .FREEZE_LAST(FREEZE_LAST), .AW(AW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_i (sda_oe_o),
  .freeze_i (freeze_o),
  .reg_wr_i (reg_wr_o),
  .stop_i   (stop_det),
  .ptr_i    (ptr_q)
);

// File: tb/tw_reg_slave_bench.sv
module tw_reg_slave_bench;
  timeunit 1ns; timeprecision 100ps;

  localparam int Q = 10;
  localparam logic [7:0] WR_ADDR = 8'hD0;
  localparam logic [7:0] RD_ADDR = 8'hD1;

  logic       clk, rst_n, scl_m, sda_m, sda_bus;
  logic       sda_oe, freeze, reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [8];
  logic [7:0] exp_mem [8];
  int         exp_ptr, n_chk, n_fail, oe_viol;
  logic       oe_prev;
  bit         done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  tw_reg_slave u_tw_reg_slave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .freeze_o    (freeze),
    .reg_addr_o  (reg_addr),
    .reg_wr_o    (reg_wr),
    .reg_wdata_o (reg_wdata),
    .reg_rdata_i (reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 3);
  endfunction
  function automatic int nxt(input int p);
    return (p == 7) ? 0 : p + 1;
  endfunction
  function automatic bit exp_frz(input int p);
    return p <= 6;
  endfunction

  // external register storage
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= init_val(i);
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  // R11 monitor: output enable may move only while SCL is low
  always @(posedge clk) begin
    #1;
    if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask
  task automatic start_c();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic stop_c();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask
  task automatic wbit(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask
  task automatic rbit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = !a;
  endtask
  task automatic recv_byte(input bit ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(!ack);
  endtask

  task automatic check_mem(input string tag);
    for (int i = 0; i < 8; i++)
      chk(mem[i] == exp_mem[i], tag, $sformatf("register %0d", i), mem[i], exp_mem[i]);
  endtask

  task automatic wr_txn(input int p, input int n);
    bit a;
    logic [7:0] d;
    start_c();
    send_byte(WR_ADDR, a); chk(a, "R2", "write address ack", a, 1);
    send_byte(8'(p), a);   chk(a, "R4", "pointer byte ack", a, 1);
    exp_ptr = p;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, a); chk(a, "R5", "data byte ack", a, 1);
      exp_mem[exp_ptr] = d;
      exp_ptr = nxt(exp_ptr);
    end
    stop_c();
    check_mem("R5");
  endtask

  task automatic rd_txn(input bit set_ptr, input int p, input int n);
    bit a, last;
    logic [7:0] d;
    string tag;
    if (set_ptr) begin
      start_c();
      send_byte(WR_ADDR, a); chk(a, "R2", "write address ack", a, 1);
      send_byte(8'(p), a);   chk(a, "R4", "pointer byte ack", a, 1);
      exp_ptr = p;
    end
    start_c();
    send_byte(RD_ADDR, a); chk(a, "R2", "read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      last = (k == n - 1);
      recv_byte(!last, d);
      if (k == 0) tag = set_ptr ? "R10" : "R8";
      else        tag = (exp_ptr == 0) ? "R7" : "R6";
      chk(d == exp_mem[exp_ptr], tag, "read data", d, exp_mem[exp_ptr]);
      if (!last) exp_ptr = nxt(exp_ptr);
      chk(freeze == exp_frz(exp_ptr), "R9", "freeze during read", freeze, exp_frz(exp_ptr));
    end
    chk(sda_oe == 1'b0, "R6", "SDA released after NACK", sda_oe, 0);
    stop_c();
    chk(freeze == 1'b0, "R9", "freeze after STOP", freeze, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      finish_run();
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    void'($urandom(32'd4711));
    n_chk = 0; n_fail = 0; oe_viol = 0; done = 0; oe_prev = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    for (int i = 0; i < 8; i++) exp_mem[i] = init_val(i);
    exp_ptr = 0;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R12", "oe in reset", sda_oe, 0);
    chk(freeze == 1'b0, "R12", "freeze in reset", freeze, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(reg_wr == 1'b0, "R12", "write strobe after reset", reg_wr, 0);
    chk(reg_addr == 3'd0, "R12", "pointer after reset", reg_addr, 0);

    // foreign addresses
    start_c();
    send_byte(8'hA0, a); chk(!a, "R3", "foreign write address ack", a, 0);
    send_byte(8'h03, a); chk(!a, "R3", "byte after mismatch ack", a, 0);
    send_byte(8'h5A, a); chk(!a, "R3", "byte after mismatch ack", a, 0);
    stop_c();
    start_c();
    send_byte(8'hD3, a); chk(!a, "R3", "foreign read address ack", a, 0);
    stop_c();
    check_mem("R3");

    // write burst across the top location, then current-location read
    wr_txn(5, 4);
    rd_txn(0, 0, 3);
    // pointer write, repeated START, read across 6 -> 7 -> 0
    rd_txn(1, 6, 3);
    // NACK leaves the pointer, so the same byte comes back
    rd_txn(0, 0, 1);
    rd_txn(0, 0, 2);

    // STOP inside a data byte, then bits with no START
    start_c();
    send_byte(WR_ADDR, a); chk(a, "R2", "write address ack", a, 1);
    send_byte(8'h02, a);   chk(a, "R4", "pointer byte ack", a, 1);
    exp_ptr = 2;
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    stop_c();
    send_byte(WR_ADDR, a); chk(!a, "R1", "ack while idle", a, 0);
    stop_c();
    // START inside a data byte restarts addressing
    start_c();
    send_byte(WR_ADDR, a); chk(a, "R2", "write address ack", a, 1);
    send_byte(8'h04, a);   chk(a, "R4", "pointer byte ack", a, 1);
    exp_ptr = 4;
    wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
    start_c();
    send_byte(RD_ADDR, a); chk(a, "R1", "address after mid-byte START", a, 1);
    recv_byte(1'b0, d);
    chk(d == exp_mem[4], "R1", "read after aborted byte", d, exp_mem[4]);
    stop_c();
    check_mem("R1");

    for (int t = 0; t < 30; t++) begin
      if ($urandom_range(1, 0) == 1) wr_txn(int'($urandom_range(7, 0)), int'($urandom_range(4, 0)));
      else rd_txn($urandom_range(2, 0) == 0, int'($urandom_range(7, 0)), int'($urandom_range(4, 1)));
    end

    chk(oe_viol == 0, "R11", "oe changes while SCL high", oe_viol, 0);
    finish_run();
  end
endmodule